// File: doc/BRIEF.md
# MIDI Running-Status Message Expander

This block sits behind a MIDI serial receiver and turns its byte stream into whole note messages. Each received byte arrives as an 8-bit value qualified by a one-cycle guard strobe. The block sorts each byte into one of two groups, status or data. It pairs data bytes into key and velocity, and emits one 24-bit word per complete note message with its own one-cycle guard strobe.

A sender may leave out a repeated status byte (running status). In that case the block reuses the last note status it accepted, so every emitted word carries status, key and velocity. A note-on with velocity zero is rewritten as a note-off on the same channel. Downstream merge logic then only ever sees explicit note-off codes for released notes.

The guard rate of the incoming bytes is very low compared with the clock: one byte per 320 clocks at 31.25 kbaud in a 1 MHz system. The block nevertheless accepts a byte on every cycle.

Top module: `midi_rs_expander`

## Requirements
- R1: After reset `out_guard` is 0, `out_msg` is 0, and no running status is held.
- R2: Only bytes whose cycle has `in_guard` high are used. A byte with bit 7 set is a status byte and a byte with bit 7 clear is a data byte. A byte presented with `in_guard` low changes neither the outputs nor the stored status.
- R3: A status byte with upper nibble 0x8 (note-off) or 0x9 (note-on) is stored. The next two data bytes are the key and the velocity. One cycle after the guarded velocity byte, `out_guard` is high for exactly one cycle. In that cycle `out_msg` is {status, key, velocity}, with status in bits 23:16, key in bits 15:8 and velocity in bits 7:0.
- R4: After a message is emitted the stored status is kept. Each later pair of data bytes produces another message with that status.
- R5: When the stored status has upper nibble 0x9 and the velocity is 0x00, the emitted status byte is 0x8 with the same channel nibble (bits 19:16). Key and velocity are unchanged, and the stored status stays 0x9n for later pairs.
- R6: Data bytes that arrive while no note status is held are discarded and produce no message.
- R7: A status byte with an upper nibble from 0xA to 0xF clears the stored status. Data bytes following it are discarded until a new 0x8n or 0x9n status arrives.
- R8: A status byte arriving after only one data byte discards that byte. The next two data bytes form a complete message under the new status.
- R9: `out_msg` keeps its last emitted value in every cycle where `out_guard` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_guard | input | 1 | One-cycle strobe qualifying `in_byte` |
| in_byte | input | 8 | Received byte |
| out_guard | output | 1 | One-cycle strobe marking a new message |
| out_msg | output | 24 | {status, key, velocity} of the last message |

## Verification
Two functions can fall in the same cycle: completing a message under reused running status, and rewriting a zero velocity. The same cycle also stores the unrewritten 0x9n status for the next pair. The bench provokes this by sending a note-on status and then back-to-back data pairs, with the guard high on every cycle, where a zero velocity follows non-zero ones. It then checks that the zero-velocity word carries 0x8n and that the next pair again carries 0x9n. Every output is compared, cycle by cycle, with a model that the bench computes from the requirements across all channels and both note kinds.

// File: rtl/midi_rs_pkg.sv
package midi_rs_pkg;

    localparam logic [3:0] NIB_NOTE_OFF = 4'h8;
    localparam logic [3:0] NIB_NOTE_ON  = 4'h9;

    typedef enum logic [1:0] {
        KIND_NONE       = 2'd0,
        KIND_DATA       = 2'd1,
        KIND_STAT_NOTE  = 2'd2,
        KIND_STAT_OTHER = 2'd3
    } byte_kind_e;

endpackage

// File: rtl/midi_byte_classify.sv
module midi_byte_classify
    import midi_rs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              guard_i,
    input  logic [BYTE_W-1:0] byte_i,
    output byte_kind_e        kind_o
);
    localparam int TOP = BYTE_W - 1;

    logic [3:0] hi_nib;
    assign hi_nib = byte_i[TOP -: 4];

    always_comb begin
        if (!guard_i) begin
            kind_o = KIND_NONE;
        end else if (!byte_i[TOP]) begin
            kind_o = KIND_DATA;
        end else if (hi_nib == NIB_NOTE_OFF || hi_nib == NIB_NOTE_ON) begin
            kind_o = KIND_STAT_NOTE;
        end else begin
            kind_o = KIND_STAT_OTHER;
        end
    end

endmodule

// File: rtl/midi_vel_zero_fix.sv
module midi_vel_zero_fix
    import midi_rs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] status_i,
    input  logic [BYTE_W-1:0] vel_i,
    output logic [BYTE_W-1:0] status_o
);
    localparam int TOP = BYTE_W - 1;

    always_comb begin
        status_o = status_i;
        if (status_i[TOP -: 4] == NIB_NOTE_ON && vel_i == '0) begin
            status_o[TOP -: 4] = NIB_NOTE_OFF;
        end
    end

endmodule

// File: rtl/midi_msg_assemble.sv
module midi_msg_assemble
    import midi_rs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  byte_kind_e          kind_i,
    input  logic [BYTE_W-1:0]   byte_i,
    output logic                guard_o,
    output logic [3*BYTE_W-1:0] msg_o
);
    localparam int MSG_W = 3 * BYTE_W;

    typedef struct packed {
        logic              have_status;
        logic              have_key;
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] key;
        logic              guard;
        logic [MSG_W-1:0]  msg;
    } asm_state_t;

    asm_state_t st_d, st_q;
    logic [BYTE_W-1:0] fixed_status;

    midi_vel_zero_fix #(.BYTE_W(BYTE_W)) i_fix (
        .status_i (st_q.status),
        .vel_i    (byte_i),
        .status_o (fixed_status)
    );

    always_comb begin
        st_d       = st_q;
        st_d.guard = 1'b0;
        case (kind_i)
            KIND_STAT_NOTE: begin
                st_d.have_status = 1'b1;
                st_d.have_key    = 1'b0;
                st_d.status      = byte_i;
            end
            KIND_STAT_OTHER: begin
                st_d.have_status = 1'b0;
                st_d.have_key    = 1'b0;
            end
            KIND_DATA: begin
                if (st_q.have_status) begin
                    if (!st_q.have_key) begin
                        st_d.key      = byte_i;
                        st_d.have_key = 1'b1;
                    end else begin
                        st_d.have_key = 1'b0;
                        st_d.guard    = 1'b1;
                        st_d.msg      = {fixed_status, st_q.key, byte_i};
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign guard_o = st_q.guard;
    assign msg_o   = st_q.msg;

    AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !guard_o |-> $stable(msg_o)) else $error("message changed without guard"); // R9
    AST_KEY_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.have_key |-> st_q.have_status) else $error("key held without status"); // R6
    AST_GUARD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        guard_o |=> !guard_o) else $error("guard longer than one cycle"); // R3

endmodule

// File: rtl/midi_rs_expander.sv
module midi_rs_expander
    import midi_rs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_guard,
    input  logic [BYTE_W-1:0]   in_byte,
    output logic                out_guard,
    output logic [3*BYTE_W-1:0] out_msg
);
    localparam int MSG_W = 3 * BYTE_W;
    localparam int S_HI  = MSG_W - 1;
    localparam int V_HI  = BYTE_W - 1;

    byte_kind_e kind;

    midi_byte_classify #(.BYTE_W(BYTE_W)) i_classify (
        .guard_i (in_guard),
        .byte_i  (in_byte),
        .kind_o  (kind)
    );

    midi_msg_assemble #(.BYTE_W(BYTE_W)) i_assemble (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind_i  (kind),
        .byte_i  (in_byte),
        .guard_o (out_guard),
        .msg_o   (out_msg)
    );

    AST_EMIT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_guard |-> $past(in_guard && !in_byte[BYTE_W-1])) else $error("emit without data byte"); // R2
    AST_NOTE_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        out_guard |-> (out_msg[S_HI -: 4] == NIB_NOTE_OFF || out_msg[S_HI -: 4] == NIB_NOTE_ON))
        else $error("non-note status emitted"); // R3
    AST_NO_ZERO_VEL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_guard && out_msg[S_HI -: 4] == NIB_NOTE_ON) |-> (out_msg[V_HI:0] != '0))
        else $error("zero-velocity note-on emitted"); // R5

endmodule

// File: tb/test_midi_rs_expander.sv
module test_midi_rs_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_guard = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_guard;
    logic [23:0] out_msg;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        m_have = 0, m_haskey = 0, exp_g = 0;
    logic [7:0]  m_stat = 0, m_key = 0;
    logic [23:0] exp_msg = 0;

    always #4 clk = ~clk;

    midi_rs_expander i_midi_rs_expander (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_guard  (in_guard),
        .in_byte   (in_byte),
        .out_guard (out_guard),
        .out_msg   (out_msg)
    );

    task automatic model(input logic [7:0] b);
        exp_g = 1'b0;
        if (b[7]) begin
            m_haskey = 1'b0;
            if (b[7:4] == 4'h8 || b[7:4] == 4'h9) begin
                m_have = 1'b1;
                m_stat = b;
            end else begin
                m_have = 1'b0;
            end
        end else if (m_have) begin
            if (!m_haskey) begin
                m_key    = b;
                m_haskey = 1'b1;
            end else begin
                m_haskey = 1'b0;
                exp_g    = 1'b1;
                exp_msg  = {(m_stat[7:4] == 4'h9 && b == 8'h00) ? {4'h8, m_stat[3:0]} : m_stat,
                            m_key, b};
            end
        end
    endtask

    task automatic chk(input string tag);
        checks++;
        if (out_guard !== exp_g || out_msg !== exp_msg) begin
            failures++;
            $display("FAIL %s actual guard=%0b msg=%06h expected guard=%0b msg=%06h",
                     tag, out_guard, out_msg, exp_g, exp_msg);
        end
    endtask

    // called at a falling edge; leaves at the next falling edge
    task automatic send(input logic [7:0] b, input string tag);
        in_guard = 1'b1;
        in_byte  = b;
        model(b);
        @(negedge clk);
        in_guard = 1'b0;
        chk(tag);
    endtask

    task automatic idle(input logic [7:0] junk, input string tag);
        in_guard = 1'b0;
        in_byte  = junk;
        exp_g    = 1'b0;
        @(negedge clk);
        chk(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1");

        // R6: data with no status held
        send(8'h3C, "R6");
        send(8'h40, "R6");
        send(8'h11, "R6");

        // R3 R4 R5: all channels, both note kinds, back-to-back pairs
        for (int k = 8; k <= 9; k++) begin
            for (int ch = 0; ch < 16; ch++) begin
                send({k[3:0], ch[3:0]}, "R3");
                for (int v = 0; v < 4; v++) begin
                    logic [7:0] vel;
                    vel = (v == 0) ? 8'h01 : (v == 1) ? 8'h00 : (v == 2) ? 8'h7F : 8'h40;
                    send(8'((ch * 7 + v * 13) & 8'h7F), "R4");
                    send(vel, (v == 1) ? "R5" : "R4");
                end
            end
        end

        // R2: unguarded bytes are ignored
        send(8'h95, "R2");
        idle(8'hA0, "R2");
        idle(8'h22, "R2");
        send(8'h30, "R2");
        idle(8'h80, "R2");
        send(8'h00, "R5");
        send(8'h31, "R2");
        send(8'h50, "R2");
        idle(8'h00, "R9");
        idle(8'h7F, "R9");

        // R7: other status classes clear running status
        for (int hi = 10; hi < 16; hi++) begin
            send(8'h92, "R7");
            send(8'h10, "R7");
            send({hi[3:0], 4'h3}, "R7");
            send(8'h20, "R7");
            send(8'h21, "R7");
            send(8'h22, "R7");
        end

        // R8: status mid-message abandons the partial pair
        send(8'h93, "R8");
        send(8'h44, "R8");
        send(8'h86, "R8");
        send(8'h45, "R8");
        send(8'h46, "R8");
        send(8'h9F, "R8");
        send(8'h12, "R8");
        send(8'h9F, "R8");
        send(8'h13, "R8");
        send(8'h00, "R5");
        send(8'h14, "R4");
        send(8'h15, "R4");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule